// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit owns an 8-bit processor status word and decides, cycle by cycle, whether one of a set of pending interrupt request lines is taken. Each request line carries a 2-bit priority level, where a smaller number means a more urgent request. Acceptance depends on two things. A global enable bit must be set. The line's level must also be no less urgent than a 2-bit in-service priority field held inside the status word. When a request wins, the unit emits a one-cycle acknowledge with the winning line's index. In the same cycle it presents the pre-change status word for the stack. It clears the enable bit and reloads the in-service field with the acknowledged level less one, or with 00 for a level-0 request.

The surrounding processor drives the rest through single-cycle strobes:
- enable and disable of interrupts;
- a software break, which saves the word and clears the enable bit whatever the state of enable and priority;
- a push, which only presents the current word;
- a full 8-bit write of the word;
- a return or pop, which reloads the whole word from a restore port.

Stack memory, vector fetch and arithmetic flags belong to the rest of the processor.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the status word output reads 0x06 (enable bit 7 = 0, in-service field bits 2:1 = 11), and the acknowledge and save-valid outputs are 0.
- R2: The enable bit is bit 7 and the in-service field is bits 2:1. An enable strobe sets bit 7 and a disable strobe clears it; when both arrive in one cycle, disable wins. The status word output changes on the clock edge that samples the strobe.
- R3: A request at level L is accepted only if bit 7 is 1 and L is less than or equal to the in-service field. The values are taken from the word as it stood in the sampling cycle. The acknowledge and its index appear in the cycle after the request was sampled, as a single-cycle pulse.
- R4: Among eligible requests, the lowest level number wins, and ties go to the lowest line index. At most one acknowledge is issued per cycle.
- R5: On acknowledge, save-valid pulses with save data equal to the word before the change. Bit 7 becomes 0 and bits 2:1 become L-1, or 00 when L is 0. All other bits are unchanged.
- R6: A break strobe is taken whatever the values of bit 7 and bits 2:1. It pulses save-valid with the pre-change word, clears bit 7, and leaves bits 2:1 unchanged. An interrupt that could have been acknowledged in the same cycle is not acknowledged.
- R7: A return strobe loads the whole word from the restore port, and a write strobe loads it from the write-data port; if both come in one cycle, the return wins. Enable, disable, break and acknowledge have no effect in such a cycle.
- R8: No acknowledge is issued for a cycle that carries a write, a return or a disable strobe. A newly written or enabled value governs acceptance from the following cycle on.
- R9: A push strobe pulses save-valid with the current word and leaves the word unchanged. When push and acknowledge fall in one cycle, both present that same pre-change word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Request lines, one bit per source |
| req_lvl_i | input | 2*N_REQ | Priority level of line i at bits [2i+1:2i] |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| brk_i | input | 1 | Software break strobe |
| push_i | input | 1 | Push-word strobe |
| psw_wr_i | input | 1 | Full word write strobe |
| psw_wdata_i | input | 8 | Write data |
| ret_i | input | 1 | Return / pop strobe |
| restore_i | input | 8 | Word restored on return |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| ack_idx_o | output | $clog2(N_REQ) | Index of acknowledged line |
| save_vld_o | output | 1 | Save data valid pulse |
| save_o | output | 8 | Word to be saved |
| psw_o | output | 8 | Current status word |

## Verification
Two pairs of functions can fall in one cycle. A break can meet an otherwise eligible request, and a push can meet an acknowledge. The bench sets up an enabled word with an eligible request and raises break or push in that same sampling cycle. For break, it expects save data equal to the old word, no acknowledge, and an unchanged in-service field. For push, it expects the acknowledge together with a single save of the pre-change word. The same method pairs requests with write, return and enable or disable strobes, to confirm which strobe takes precedence and that the effect is delayed by one cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PSW_W     = 8;
    localparam int LVL_W     = 2;
    localparam int IE_BIT    = 7;
    localparam int ISP_LO    = 1;
    localparam int ISP_HI    = ISP_LO + LVL_W - 1;
    localparam logic [PSW_W-1:0] PSW_RESET = 8'h06;

    typedef logic [PSW_W-1:0] psw_t;
    typedef logic [LVL_W-1:0] lvl_t;

    function automatic lvl_t next_isp(input lvl_t lvl);
        return (lvl == '0) ? '0 : lvl_t'(lvl - 1'b1);
    endfunction
endpackage

// File: rtl/irq_level_filter.sv
module irq_level_filter
    import irq_pkg::*;
#(
    parameter int N_REQ = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       req_i,
    input  logic [N_REQ*LVL_W-1:0] lvl_i,
    input  logic                   ie_i,
    input  lvl_t                   isp_i,
    input  logic                   block_i,
    output logic [N_REQ-1:0]       elig_o
);
    genvar gi;
    generate
        for (gi = 0; gi < N_REQ; gi++) begin : g_line
            lvl_t line_lvl;
            assign line_lvl    = lvl_i[gi*LVL_W +: LVL_W];
            assign elig_o[gi]  = req_i[gi] & ie_i & ~block_i & (line_lvl <= isp_i);
        end
    endgenerate

    // R3: nothing is eligible while interrupts are disabled or blocked
    p_no_elig_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_i || block_i) |-> (elig_o == '0));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter int N_REQ = 8,
    localparam int IDX_W = $clog2(N_REQ),
    localparam int N_LVL = 1 << LVL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       elig_i,
    input  logic [N_REQ*LVL_W-1:0] lvl_i,
    output logic                   win_vld_o,
    output logic [IDX_W-1:0]       win_idx_o,
    output lvl_t                   win_lvl_o
);
    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int l = 0; l < N_LVL; l++) begin
            for (int i = 0; i < N_REQ; i++) begin
                if (!win_vld_o && elig_i[i] &&
                    (lvl_i[i*LVL_W +: LVL_W] == lvl_t'(l))) begin
                    win_vld_o = 1'b1;
                    win_idx_o = IDX_W'(i);
                    win_lvl_o = lvl_t'(l);
                end
            end
        end
    end

    // R4: the winner is always an eligible line
    p_win_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> elig_i[win_idx_o]);
    // R4: any eligible line produces a winner
    p_win_when_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_i != '0) |-> win_vld_o);
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter int N_REQ = 8,
    localparam int IDX_W = $clog2(N_REQ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       req_i,
    input  logic [N_REQ*LVL_W-1:0] req_lvl_i,
    input  logic                   ei_i,
    input  logic                   di_i,
    input  logic                   brk_i,
    input  logic                   push_i,
    input  logic                   psw_wr_i,
    input  logic [PSW_W-1:0]       psw_wdata_i,
    input  logic                   ret_i,
    input  logic [PSW_W-1:0]       restore_i,
    output logic                   ack_o,
    output logic [IDX_W-1:0]       ack_idx_o,
    output logic                   save_vld_o,
    output logic [PSW_W-1:0]       save_o,
    output logic [PSW_W-1:0]       psw_o
);
    typedef struct packed {
        psw_t             psw;
        logic             ack;
        logic [IDX_W-1:0] idx;
        logic             sv;
        psw_t             save;
    } state_t;

    state_t st_d, st_q;

    logic [N_REQ-1:0] elig;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;
    logic             ack_block;

    assign ack_block = psw_wr_i | ret_i | di_i | brk_i;

    irq_level_filter #(.N_REQ(N_REQ)) filter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .lvl_i   (req_lvl_i),
        .ie_i    (st_q.psw[IE_BIT]),
        .isp_i   (st_q.psw[ISP_HI:ISP_LO]),
        .block_i (ack_block),
        .elig_o  (elig)
    );

    irq_pick #(.N_REQ(N_REQ)) pick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig_i    (elig),
        .lvl_i     (req_lvl_i),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        st_d.sv   = 1'b0;
        if (push_i) begin
            st_d.sv   = 1'b1;
            st_d.save = st_q.psw;
        end
        if (ret_i) begin
            st_d.psw = restore_i;
        end else if (psw_wr_i) begin
            st_d.psw = psw_wdata_i;
        end else begin
            if (di_i) begin
                st_d.psw[IE_BIT] = 1'b0;
            end else if (ei_i) begin
                st_d.psw[IE_BIT] = 1'b1;
            end
            if (brk_i) begin
                st_d.sv          = 1'b1;
                st_d.save        = st_q.psw;
                st_d.psw[IE_BIT] = 1'b0;
            end else if (win_vld) begin
                st_d.ack                  = 1'b1;
                st_d.idx                  = win_idx;
                st_d.sv                   = 1'b1;
                st_d.save                 = st_q.psw;
                st_d.psw[IE_BIT]          = 1'b0;
                st_d.psw[ISP_HI:ISP_LO]   = next_isp(win_lvl);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.psw  <= PSW_RESET;
            st_q.ack  <= 1'b0;
            st_q.idx  <= '0;
            st_q.sv   <= 1'b0;
            st_q.save <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o      = st_q.ack;
    assign ack_idx_o  = st_q.idx;
    assign save_vld_o = st_q.sv;
    assign save_o     = st_q.save;
    assign psw_o      = st_q.psw;

    // R3: an acknowledge needs the enable bit set in the sampling cycle
    p_ack_needs_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(psw_o[IE_BIT]));
    // R5: acknowledge leaves interrupts disabled and saves the old word
    p_ack_clears_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (!psw_o[IE_BIT] && save_vld_o && save_o == $past(psw_o)));
    // R5: in-service field follows the acknowledged level
    p_ack_isp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (psw_o[ISP_HI:ISP_LO] == next_isp($past(win_lvl))));
    // R8: blocked cycles never produce an acknowledge
    p_no_ack_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_block |=> !ack_o);
    // R6: break keeps the in-service field and clears enable
    p_brk_isp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !ret_i && !psw_wr_i) |=>
            (psw_o[ISP_HI:ISP_LO] == $past(psw_o[ISP_HI:ISP_LO]) && !psw_o[IE_BIT] && save_vld_o));
    // R7: return reloads the full word
    p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> (psw_o == $past(restore_i)));
    // R9: push presents the current word
    p_push_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (save_vld_o && save_o == $past(psw_o)));
endmodule

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb_top;
    localparam int N   = 8;
    localparam int IW  = $clog2(N);
    localparam bit O   = 1'b0;
    localparam bit I   = 1'b1;

    typedef struct packed {
        logic [7:0]    init;
        logic [N-1:0]  req;
        logic [2*N-1:0] lvl;
        logic          ei, di, brk, push, wr;
        logic [7:0]    wdata;
        logic          ret;
        logic [7:0]    rdata;
        logic          e_ack;
        logic [IW-1:0] e_idx;
        logic [7:0]    e_psw;
        logic          e_sv;
        logic [7:0]    e_save;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'h86, 8'h01, 16'hFFFF, O,O,O,O,O, 8'h00, O, 8'h00, I, 3'd0, 8'h04, I, 8'h86}, // R3 R5
        '{8'h06, 8'h01, 16'hFFFF, O,O,O,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h06, O, 8'h00}, // R3 IE off
        '{8'h82, 8'h08, 16'hFFBF, O,O,O,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h82, O, 8'h00}, // R3 level too low
        '{8'h82, 8'h08, 16'hFF7F, O,O,O,O,O, 8'h00, O, 8'h00, I, 3'd3, 8'h00, I, 8'h82}, // R5 L1 -> 00
        '{8'h87, 8'hF0, 16'h97FF, O,O,O,O,O, 8'h00, O, 8'h00, I, 3'd5, 8'h01, I, 8'h87}, // R4 tie
        '{8'hFF, 8'h04, 16'hFFCF, O,O,O,O,O, 8'h00, O, 8'h00, I, 3'd2, 8'h79, I, 8'hFF}, // R5 L0
        '{8'h02, 8'h00, 16'hFFFF, O,O,I,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h02, I, 8'h02}, // R6 IE off
        '{8'h86, 8'h01, 16'hFFFF, O,O,I,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h06, I, 8'h86}, // R6 vs request
        '{8'h55, 8'h00, 16'hFFFF, O,O,O,I,O, 8'h00, O, 8'h00, O, 3'd0, 8'h55, I, 8'h55}, // R9
        '{8'h06, 8'h00, 16'hFFFF, I,O,O,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h86, O, 8'h00}, // R2 ei
        '{8'h86, 8'h00, 16'hFFFF, I,I,O,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h06, O, 8'h00}, // R2 di wins
        '{8'h86, 8'h01, 16'hFFFF, O,I,O,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h06, O, 8'h00}, // R8 di
        '{8'h06, 8'h01, 16'hFFFF, I,O,O,O,O, 8'h00, O, 8'h00, O, 3'd0, 8'h86, O, 8'h00}, // R8 ei late
        '{8'h86, 8'h01, 16'hFFFF, I,O,O,O,O, 8'h00, O, 8'h00, I, 3'd0, 8'h04, I, 8'h86}, // R5 ei+ack
        '{8'h86, 8'h01, 16'hFFFF, O,O,O,I,O, 8'h00, O, 8'h00, I, 3'd0, 8'h04, I, 8'h86}, // R9 push+ack
        '{8'h86, 8'h01, 16'hFFFF, O,O,I,O,O, 8'h00, I, 8'h3C, O, 3'd0, 8'h3C, O, 8'h00}, // R7 ret
        '{8'h86, 8'h01, 16'hFFFF, O,O,O,O,I, 8'hA1, O, 8'h00, O, 3'd0, 8'hA1, O, 8'h00}, // R7 write
        '{8'h86, 8'h00, 16'hFFFF, O,O,O,O,I, 8'h11, I, 8'h22, O, 3'd0, 8'h22, O, 8'h00}, // R7 ret wins
        '{8'h80, 8'h03, 16'hFFF1, O,O,O,O,O, 8'h00, O, 8'h00, I, 3'd1, 8'h00, I, 8'h80}  // R4 level 0 only
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_i = '0;
    logic [2*N-1:0] req_lvl_i = '1;
    logic           ei_i = 1'b0, di_i = 1'b0, brk_i = 1'b0, push_i = 1'b0;
    logic           psw_wr_i = 1'b0, ret_i = 1'b0;
    logic [7:0]     psw_wdata_i = '0, restore_i = '0;
    logic           ack_o, save_vld_o;
    logic [IW-1:0]  ack_idx_o;
    logic [7:0]     save_o, psw_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_accept_unit #(.N_REQ(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_lvl_i(req_lvl_i),
        .ei_i(ei_i), .di_i(di_i), .brk_i(brk_i), .push_i(push_i),
        .psw_wr_i(psw_wr_i), .psw_wdata_i(psw_wdata_i), .ret_i(ret_i),
        .restore_i(restore_i), .ack_o(ack_o), .ack_idx_o(ack_idx_o),
        .save_vld_o(save_vld_o), .save_o(save_o), .psw_o(psw_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_i = '0; req_lvl_i = '1; ei_i = 0; di_i = 0; brk_i = 0; push_i = 0;
        psw_wr_i = 0; psw_wdata_i = '0; ret_i = 0; restore_i = '0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 psw", psw_o, 8'h06);
        check("R1 ack", ack_o, 0);
        check("R1 save_vld", save_vld_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 psw after release", psw_o, 8'h06);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            idle();
            psw_wr_i = 1'b1; psw_wdata_i = VEC[v].init;
            @(negedge clk);
            psw_wr_i = VEC[v].wr; psw_wdata_i = VEC[v].wdata;
            req_i = VEC[v].req; req_lvl_i = VEC[v].lvl;
            ei_i = VEC[v].ei; di_i = VEC[v].di; brk_i = VEC[v].brk; push_i = VEC[v].push;
            ret_i = VEC[v].ret; restore_i = VEC[v].rdata;
            @(negedge clk);
            idle();
            check($sformatf("vec%0d ack", v), ack_o, VEC[v].e_ack);
            if (VEC[v].e_ack) check($sformatf("vec%0d ack_idx", v), ack_idx_o, VEC[v].e_idx);
            check($sformatf("vec%0d psw", v), psw_o, VEC[v].e_psw);
            check($sformatf("vec%0d save_vld", v), save_vld_o, VEC[v].e_sv);
            if (VEC[v].e_sv) check($sformatf("vec%0d save", v), save_o, VEC[v].e_save);
        end

        // R8: write with request held; acceptance starts one cycle later
        @(negedge clk);
        idle();
        psw_wr_i = 1'b1; psw_wdata_i = 8'h86; req_i = 8'h40;
        req_lvl_i = 16'hEFFF; // line 6 at level 2
        @(negedge clk);
        psw_wr_i = 1'b0;
        check("R8 no ack in write cycle", ack_o, 0);
        check("R8 written word", psw_o, 8'h86);
        @(negedge clk);
        idle();
        check("R8 ack next cycle", ack_o, 1);
        check("R8 ack idx", ack_idx_o, 6);
        check("R5 isp after L2", psw_o, 8'h02);
        @(negedge clk);
        // R3: acknowledge is a single pulse
        check("R3 ack one cycle", ack_o, 0);
        check("R3 save_vld one cycle", save_vld_o, 0);

        // R1: reset again restores 0x06
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 psw on re-reset", psw_o, 8'h06);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule